// File: doc/BRIEF.md
# Interrupt Entry and Return Sequencer

This block is the CPU-side control unit that carries out the hardware steps of taking a maskable interrupt and of returning from it. It owns the architectural flags word, code selector, instruction pointer and stack pointer. In the idle state, the core reports each finished instruction by pulsing `instr_done` together with the address of the next instruction. If an interrupt request is present at that boundary and the interrupt-enable bit of the flags is set, the sequencer captures the 8-bit vector and acknowledges it. It then pushes the return state onto a downward-growing 32-bit stack and masks further interrupts. Next it fetches the 8-byte gate descriptor for the vector from a 256-entry table, decodes it and jumps to the handler.

When the core executes the return instruction, it pulses `iret_req`. The sequencer then pops the instruction pointer, the code selector and the flags word, which restores the interrupt-enable bit to its state before entry. All memory traffic uses a single word-wide valid/ready port. A descriptor that is absent or is not an interrupt gate sends the sequencer into a halted fault state.

Top module: `intr_seq`

## Requirements
- R1: A request on `irq_req` is taken only in the cycle that `instr_done` is high, the sequencer is idle and flags bit 9 (interrupt enable) is 1. If bit 9 is 0 or `instr_done` is 0, the request is ignored: no memory access, `busy` stays low and `sp_o` is unchanged. In idle, every `instr_done` loads `next_ip` into `ip_o`.
- R2: `irq_ack` is high for exactly one cycle, in the cycle after the clock edge that captures the vector. `busy` rises in the same cycle and falls in the cycle in which `ip_o` already shows the handler address.
- R3: Entry makes three writes. The full flags word goes to `sp-4`, the code selector zero-extended to 32 bits goes to `sp-8`, and the captured `next_ip` goes to `sp-12`. Each completed write lowers `sp_o` by 4, so `sp_o` ends 12 below its start.
- R4: Flags bit 9 is cleared only after the third push completes. The pushed flags word still carries bit 9 = 1.
- R5: After the pushes, the sequencer reads the descriptor words at `idt_base + 8*vector` and then at `idt_base + 8*vector + 4`.
- R6: The descriptor is decoded as follows. The first word's bits 15:0 are offset 15:0 and its bits 31:16 are the selector. In the second word, bits 4:0 are a count, bits 7:5 are reserved, bits 11:8 are the type, bit 12 is the descriptor-type bit, bits 14:13 are the privilege and bit 15 is present, while bits 31:16 are offset 31:16. On a good gate, `cs_o` takes the selector and `ip_o` takes the full offset. `gate_odd` is set when the privilege, descriptor-type bit, count or reserved bits are nonzero, or the selector is not 8.
- R7: A descriptor with present = 0 or type ≠ 0xE raises `fault`, leaves `cs_o` and `ip_o` unchanged, keeps `busy` high and stops all further memory requests until reset.
- R8: `iret_req` in idle pops the instruction pointer from `sp`, the selector (bits 15:0) from `sp+4` and the flags from `sp+8`, raising `sp_o` by 4 per read and restoring the flags word in full.
- R9: A memory request holds `mem_valid`, `mem_we`, `mem_addr` and `mem_wdata` steady until the cycle in which `mem_ready` is seen high.
- R10: In idle, a `set_if` pulse sets flags bit 9 and a `clr_if` pulse clears it; `set_if` wins if both are high.
- R11: After reset: `sp_o` = 0x1000, `cs_o` = 0x0008, `ip_o` = 0, `flags_o` = 0x00000002, and `busy`, `fault`, `irq_ack` and `mem_valid` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_done | input | 1 | Instruction boundary strobe |
| next_ip | input | 32 | Address of the next sequential instruction |
| set_if | input | 1 | Enable maskable interrupts |
| clr_if | input | 1 | Mask maskable interrupts |
| iret_req | input | 1 | Start the return sequence |
| irq_req | input | 1 | Interrupt request from the controller |
| irq_vec | input | 8 | Vector number of the request |
| irq_ack | output | 1 | Vector captured |
| idt_base | input | 32 | Byte address of descriptor table |
| mem_valid | output | 1 | Memory request valid |
| mem_we | output | 1 | Write request |
| mem_addr | output | 32 | Word byte address |
| mem_wdata | output | 32 | Write data |
| mem_ready | input | 1 | Memory accepts or completes the transfer |
| mem_rdata | input | 32 | Read data, valid with ready |
| busy | output | 1 | Sequence in progress |
| fault | output | 1 | Bad gate seen, halted |
| gate_odd | output | 1 | Last gate had non-default attributes |
| cs_o | output | 16 | Code selector |
| ip_o | output | 32 | Instruction pointer |
| sp_o | output | 32 | Stack pointer |
| flags_o | output | 32 | Flags word |

## Verification
The bench sweeps all 256 vectors through a full entry and a matching return. Each vector gets its own offset pattern, so a swap of halfwords or a wrong table stride shows up, and its selector and privilege vary, so `gate_odd` is driven both ways. Memory ready follows a pseudo-random pattern that causes stalls, which separates correct waiting from requests that drift during a stall. Masked requests and requests held between instruction boundaries test that sampling happens only at boundaries with interrupts enabled. Separate runs with an absent gate and with a wrong gate type check that a bad gate halts the sequencer rather than jumping.

// File: rtl/intr_seq_pkg.sv
package intr_seq_pkg;

  typedef enum logic [3:0] {
    S_IDLE,
    S_PUSH_FL,
    S_PUSH_CS,
    S_PUSH_IP,
    S_RD_LO,
    S_RD_HI,
    S_DECODE,
    S_POP_IP,
    S_POP_CS,
    S_POP_FL,
    S_HALT
  } seq_state_t;

  typedef struct packed {
    logic        present;
    logic [1:0]  dpl;
    logic        dt;
    logic [3:0]  kind;
    logic [2:0]  rsvd;
    logic [4:0]  cnt;
    logic [15:0] sel;
    logic [31:0] target;
  } gate_t;

  localparam logic [3:0]  GATE_KIND_INTR = 4'hE;
  localparam logic [15:0] GATE_EXP_SEL   = 16'h0008;

  function automatic logic is_push(input seq_state_t s);
    return (s == S_PUSH_FL) || (s == S_PUSH_CS) || (s == S_PUSH_IP);
  endfunction

  function automatic logic is_pop(input seq_state_t s);
    return (s == S_POP_IP) || (s == S_POP_CS) || (s == S_POP_FL);
  endfunction

  function automatic logic is_mem(input seq_state_t s);
    return is_push(s) || is_pop(s) || (s == S_RD_LO) || (s == S_RD_HI);
  endfunction

endpackage

// File: rtl/intr_gate_decode.sv
module intr_gate_decode
  import intr_seq_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  logic [WORD_W-1:0] lo_word,
  input  logic [WORD_W-1:0] hi_word,
  output logic [31:0]       target,
  output logic [15:0]       sel,
  output logic              bad,
  output logic              odd
);
  gate_t g;

  always_comb begin
    g.target  = {hi_word[31:16], lo_word[15:0]};
    g.sel     = lo_word[31:16];
    g.present = hi_word[15];
    g.dpl     = hi_word[14:13];
    g.dt      = hi_word[12];
    g.kind    = hi_word[11:8];
    g.rsvd    = hi_word[7:5];
    g.cnt     = hi_word[4:0];
  end

  assign target = g.target;
  assign sel    = g.sel;
  assign bad    = !g.present || (g.kind != GATE_KIND_INTR);
  assign odd    = (g.dpl != 2'd0) || g.dt || (g.cnt != 5'd0) ||
                  (g.rsvd != 3'd0) || (g.sel != GATE_EXP_SEL);
endmodule

// File: rtl/intr_sp_unit.sv
module intr_sp_unit #(
  parameter int          ADDR_W     = 32,
  parameter int          WORD_BYTES = 4,
  parameter logic [31:0] RESET_SP   = 32'h0000_1000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              dec,
  input  logic              inc,
  output logic [ADDR_W-1:0] sp,
  output logic [ADDR_W-1:0] sp_next
);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(WORD_BYTES);

  always_comb begin
    if (dec)      sp_next = sp - STEP;
    else if (inc) sp_next = sp + STEP;
    else          sp_next = sp;
  end

  always_ff @(posedge clk) begin
    if (rst) sp <= ADDR_W'(RESET_SP);
    else     sp <= sp_next;
  end
endmodule

// File: rtl/intr_seq.sv
module intr_seq
  import intr_seq_pkg::*;
#(
  parameter int          VEC_W       = 8,
  parameter int          IF_BIT      = 9,
  parameter logic [31:0] RESET_FLAGS = 32'h0000_0002,
  parameter logic [15:0] RESET_CS    = 16'h0008,
  parameter logic [31:0] RESET_IP    = 32'h0000_0000,
  parameter logic [31:0] RESET_SP    = 32'h0000_1000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             instr_done,
  input  logic [31:0]      next_ip,
  input  logic             set_if,
  input  logic             clr_if,
  input  logic             iret_req,
  input  logic             irq_req,
  input  logic [VEC_W-1:0] irq_vec,
  output logic             irq_ack,
  input  logic [31:0]      idt_base,
  output logic             mem_valid,
  output logic             mem_we,
  output logic [31:0]      mem_addr,
  output logic [31:0]      mem_wdata,
  input  logic             mem_ready,
  input  logic [31:0]      mem_rdata,
  output logic             busy,
  output logic             fault,
  output logic             gate_odd,
  output logic [15:0]      cs_o,
  output logic [31:0]      ip_o,
  output logic [31:0]      sp_o,
  output logic [31:0]      flags_o
);
  localparam int          ADDR_W     = 32;
  localparam int          WORD_BYTES = ADDR_W / 8;
  localparam int          GATE_SHIFT = 3;
  localparam logic [31:0] WORD_STEP  = 32'(WORD_BYTES);

  seq_state_t st, st_nxt;
  logic             xfer, cap;
  logic [VEC_W-1:0] vec_q;
  logic [31:0]      desc_lo, desc_hi;
  logic [31:0]      sp_next;
  logic [31:0]      gate_target;
  logic [15:0]      gate_sel;
  logic             gate_bad, gate_nonstd;
  logic [31:0]      gate_addr;
  logic             stay_idle;

  assign xfer      = mem_valid && mem_ready;
  assign gate_addr = idt_base + (32'(vec_q) << GATE_SHIFT);
  assign stay_idle = (st == S_IDLE) && (st_nxt == S_IDLE);

  // Next-state logic
  always_comb begin
    st_nxt = st;
    cap    = 1'b0;
    unique case (st)
      S_IDLE: begin
        if (iret_req) st_nxt = S_POP_IP;
        else if (instr_done && irq_req && flags_o[IF_BIT]) begin
          st_nxt = S_PUSH_FL;
          cap    = 1'b1;
        end
      end
      S_PUSH_FL: if (xfer) st_nxt = S_PUSH_CS;
      S_PUSH_CS: if (xfer) st_nxt = S_PUSH_IP;
      S_PUSH_IP: if (xfer) st_nxt = S_RD_LO;
      S_RD_LO:   if (xfer) st_nxt = S_RD_HI;
      S_RD_HI:   if (xfer) st_nxt = S_DECODE;
      S_DECODE:  st_nxt = gate_bad ? S_HALT : S_IDLE;
      S_POP_IP:  if (xfer) st_nxt = S_POP_CS;
      S_POP_CS:  if (xfer) st_nxt = S_POP_FL;
      S_POP_FL:  if (xfer) st_nxt = S_IDLE;
      S_HALT:    st_nxt = S_HALT;
      default:   st_nxt = S_HALT;
    endcase
  end

  intr_sp_unit #(
    .ADDR_W    (ADDR_W),
    .WORD_BYTES(WORD_BYTES),
    .RESET_SP  (RESET_SP)
  ) i_sp (
    .clk    (clk),
    .rst    (rst),
    .dec    (xfer && mem_we),
    .inc    (xfer && !mem_we && is_pop(st)),
    .sp     (sp_o),
    .sp_next(sp_next)
  );

  intr_gate_decode #(.WORD_W(32)) i_dec (
    .lo_word(desc_lo),
    .hi_word(desc_hi),
    .target (gate_target),
    .sel    (gate_sel),
    .bad    (gate_bad),
    .odd    (gate_nonstd)
  );

  // Sequencer state, captured vector and descriptor words
  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= S_IDLE;
      vec_q   <= '0;
      desc_lo <= '0;
      desc_hi <= '0;
    end else begin
      st <= st_nxt;
      if (cap) vec_q <= irq_vec;
      if (xfer && st == S_RD_LO) desc_lo <= mem_rdata;
      if (xfer && st == S_RD_HI) desc_hi <= mem_rdata;
    end
  end

  // Architectural registers
  always_ff @(posedge clk) begin
    if (rst) begin
      ip_o     <= RESET_IP;
      cs_o     <= RESET_CS;
      flags_o  <= RESET_FLAGS;
      gate_odd <= 1'b0;
    end else begin
      if (cap || (stay_idle && instr_done))         ip_o <= next_ip;
      else if (xfer && st == S_POP_IP)              ip_o <= mem_rdata;
      else if (st == S_DECODE && !gate_bad)         ip_o <= gate_target;

      if (xfer && st == S_POP_CS)                   cs_o <= mem_rdata[15:0];
      else if (st == S_DECODE && !gate_bad)         cs_o <= gate_sel;

      if (st == S_DECODE)                           gate_odd <= gate_nonstd;

      if (xfer && st == S_PUSH_IP)                  flags_o[IF_BIT] <= 1'b0;
      else if (xfer && st == S_POP_FL)              flags_o <= mem_rdata;
      else if (stay_idle && set_if)                 flags_o[IF_BIT] <= 1'b1;
      else if (stay_idle && clr_if)                 flags_o[IF_BIT] <= 1'b0;
    end
  end

  // Registered memory request and status, derived from the next state
  always_ff @(posedge clk) begin
    if (rst) begin
      mem_valid <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      irq_ack   <= 1'b0;
      busy      <= 1'b0;
      fault     <= 1'b0;
    end else begin
      mem_valid <= is_mem(st_nxt);
      mem_we    <= is_push(st_nxt);
      unique case (st_nxt)
        S_PUSH_FL, S_PUSH_CS, S_PUSH_IP: mem_addr <= sp_next - WORD_STEP;
        S_RD_LO:                         mem_addr <= gate_addr;
        S_RD_HI:                         mem_addr <= gate_addr + WORD_STEP;
        S_POP_IP, S_POP_CS, S_POP_FL:    mem_addr <= sp_next;
        default:                         mem_addr <= mem_addr;
      endcase
      unique case (st_nxt)
        S_PUSH_FL: mem_wdata <= flags_o;
        S_PUSH_CS: mem_wdata <= {16'h0000, cs_o};
        S_PUSH_IP: mem_wdata <= ip_o;
        default:   mem_wdata <= mem_wdata;
      endcase
      irq_ack <= cap;
      busy    <= (st_nxt != S_IDLE);
      fault   <= (st_nxt == S_HALT);
    end
  end

  // Assertions
  AST_MASKED_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (st == S_IDLE && !flags_o[IF_BIT] && !iret_req) |=> !busy && !mem_valid); // R1
  AST_ACK_PULSE: assert property (@(posedge clk) disable iff (rst)
    irq_ack |=> !irq_ack); // R2
  AST_ACK_BUSY: assert property (@(posedge clk) disable iff (rst)
    irq_ack |-> busy); // R2
  AST_PUSH_DOWN: assert property (@(posedge clk) disable iff (rst)
    (mem_valid && mem_ready && mem_we) |=> sp_o == $past(sp_o) - WORD_STEP); // R3
  AST_IF_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (st == S_RD_LO) |-> !flags_o[IF_BIT]); // R4
  AST_FAULT_STICKY: assert property (@(posedge clk) disable iff (rst)
    fault |=> fault && busy && !mem_valid); // R7
  AST_POP_UP: assert property (@(posedge clk) disable iff (rst)
    (mem_valid && mem_ready && !mem_we && is_pop(st)) |=> sp_o == $past(sp_o) + WORD_STEP); // R8
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    (mem_valid && !mem_ready) |=> mem_valid && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)); // R9
endmodule

// File: tb/test_intr_seq.sv
module test_intr_seq;
  localparam logic [31:0] IDT = 32'h0000_0400;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        instr_done = 1'b0, set_if = 1'b0, clr_if = 1'b0, iret_req = 1'b0, irq_req = 1'b0;
  logic [31:0] next_ip = '0;
  logic [7:0]  irq_vec = '0;
  logic        irq_ack, mem_valid, mem_we, busy, fault, gate_odd;
  logic [31:0] mem_addr, mem_wdata, mem_rdata, ip_o, sp_o, flags_o;
  logic [15:0] cs_o;
  logic        mem_ready = 1'b0;
  logic [7:0]  lf = 8'h5B;
  logic [31:0] stk [16];
  int          bad_mode = 0;
  int          n_chk = 0, n_fail = 0, hs_bad = 0, stalls = 0, log_n = 0;
  logic [31:0] log_a [8];
  logic        log_w [8];

  always #2.5 clk = ~clk;

  intr_seq i_intr_seq (
    .clk(clk), .rst(rst), .instr_done(instr_done), .next_ip(next_ip),
    .set_if(set_if), .clr_if(clr_if), .iret_req(iret_req), .irq_req(irq_req),
    .irq_vec(irq_vec), .irq_ack(irq_ack), .idt_base(IDT), .mem_valid(mem_valid),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ready(mem_ready),
    .mem_rdata(mem_rdata), .busy(busy), .fault(fault), .gate_odd(gate_odd),
    .cs_o(cs_o), .ip_o(ip_o), .sp_o(sp_o), .flags_o(flags_o)
  );

  function automatic logic [31:0] off_of(input logic [7:0] v);
    return {v, ~v, 8'h3C, v ^ 8'hA5};
  endfunction
  function automatic logic [15:0] sel_of(input logic [7:0] v);
    return v[0] ? 16'h0008 : {5'd0, v, 3'd0};
  endfunction
  function automatic logic [7:0] attr_of(input logic [7:0] v);
    if (bad_mode == 1) return 8'h0E;
    if (bad_mode == 2) return 8'h8F;
    return {1'b1, v[7:6], 1'b0, 4'hE};
  endfunction

  // Memory model: descriptors computed, stack in a small array
  always_comb begin
    if (mem_addr >= IDT && mem_addr < IDT + 32'd2048) begin
      if (!mem_addr[2]) mem_rdata = {sel_of(8'((mem_addr - IDT) >> 3)), off_of(8'((mem_addr - IDT) >> 3))[15:0]};
      else              mem_rdata = {off_of(8'((mem_addr - IDT) >> 3))[31:16], attr_of(8'((mem_addr - IDT) >> 3)), 8'h00};
    end else mem_rdata = stk[mem_addr[5:2]];
  end

  always @(posedge clk) begin
    lf        <= {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
    mem_ready <= lf[0] | lf[2];
    if (mem_valid && mem_ready && mem_we) stk[mem_addr[5:2]] <= mem_wdata;
  end

  // Transfer log and request-hold monitor
  logic        pv = 1'b0, pr = 1'b0, pw = 1'b0;
  logic [31:0] pa = '0, pd = '0;
  always @(negedge clk) begin
    if (!rst && pv && !pr) begin
      stalls++;
      if (!(mem_valid && mem_addr == pa && mem_we == pw && mem_wdata == pd)) hs_bad++;
    end
    if (mem_valid && mem_ready && log_n < 8) begin
      log_a[log_n] = mem_addr;
      log_w[log_n] = mem_we;
      log_n++;
    end
    pv = mem_valid; pr = mem_ready; pa = mem_addr; pw = mem_we; pd = mem_wdata;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic wait_idle();
    for (int k = 0; k < 400; k++) begin
      @(negedge clk);
      if (!busy) break;
    end
  endtask

  task automatic pulse_irq(input logic [7:0] v, input logic [31:0] nip);
    log_n = 0;
    instr_done = 1'b1; irq_req = 1'b1; irq_vec = v; next_ip = nip;
    @(negedge clk);
    instr_done = 1'b0; irq_req = 1'b0;
  endtask

  task automatic do_entry(input logic [7:0] v, input logic [31:0] nip);
    pulse_irq(v, nip);
    chk("R2 ack after capture", 32'(irq_ack), 32'd1);
    chk("R2 busy after capture", 32'(busy), 32'd1);
    @(negedge clk);
    chk("R2 ack single cycle", 32'(irq_ack), 32'd0);
    wait_idle();
    chk("R3 transfer count", 32'(log_n), 32'd5);
    chk("R3 push flags addr", log_a[0], 32'h0FFC);
    chk("R3 push cs addr", log_a[1], 32'h0FF8);
    chk("R3 push ip addr", log_a[2], 32'h0FF4);
    chk("R3 push kinds", {29'd0, log_w[0], log_w[1], log_w[2]}, 32'd7);
    chk("R5 gate low addr", log_a[3], IDT + {21'd0, v, 3'd0});
    chk("R5 gate high addr", log_a[4], IDT + {21'd0, v, 3'd0} + 32'd4);
    chk("R4 pushed flags keep enable", stk[15], 32'h0000_0202);
    chk("R3 pushed cs widened", stk[14], 32'h0000_0008);
    chk("R3 pushed ip", stk[13], nip);
    chk("R3 sp after entry", sp_o, 32'h0FF4);
    chk("R4 enable cleared", flags_o, 32'h0000_0002);
    chk("R6 cs from gate", 32'(cs_o), 32'(sel_of(v)));
    chk("R6 ip from gate", ip_o, off_of(v));
    chk("R6 odd attributes", 32'(gate_odd), 32'(!v[0] || v[7:6] != 2'd0));
  endtask

  task automatic do_return(input logic [31:0] nip);
    log_n = 0;
    iret_req = 1'b1;
    @(negedge clk);
    iret_req = 1'b0;
    wait_idle();
    chk("R8 pop count", 32'(log_n), 32'd3);
    chk("R8 pop addrs", {log_a[0][15:0], log_a[2][15:0]}, 32'h0FF4_0FFC);
    chk("R8 pop middle", log_a[1], 32'h0FF8);
    chk("R8 ip restored", ip_o, nip);
    chk("R8 cs restored", 32'(cs_o), 32'h8);
    chk("R8 flags restored", flags_o, 32'h0000_0202);
    chk("R8 sp restored", sp_o, 32'h1000);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) stk[i] = '0;
    do_reset();
    // R11 reset state
    chk("R11 sp", sp_o, 32'h1000);
    chk("R11 cs", 32'(cs_o), 32'h8);
    chk("R11 ip", ip_o, 32'h0);
    chk("R11 flags", flags_o, 32'h2);
    chk("R11 idle outputs", {28'd0, busy, fault, irq_ack, mem_valid}, 32'd0);

    // R1 masked request
    pulse_irq(8'h20, 32'h0000_1234);
    repeat (4) @(negedge clk);
    chk("R1 masked no busy", 32'(busy), 32'd0);
    chk("R1 masked no access", 32'(log_n), 32'd0);
    chk("R1 masked sp", sp_o, 32'h1000);
    chk("R1 ip follows boundary", ip_o, 32'h0000_1234);

    // R10 enable control
    set_if = 1'b1; @(negedge clk); set_if = 1'b0;
    chk("R10 set", flags_o, 32'h202);
    clr_if = 1'b1; @(negedge clk); clr_if = 1'b0;
    chk("R10 clear", flags_o, 32'h2);
    set_if = 1'b1; clr_if = 1'b1; @(negedge clk); set_if = 1'b0; clr_if = 1'b0;
    chk("R10 set wins", flags_o, 32'h202);

    // R1 request held away from a boundary
    log_n = 0;
    irq_req = 1'b1; irq_vec = 8'h21;
    repeat (4) @(negedge clk);
    irq_req = 1'b0;
    @(negedge clk);
    chk("R1 no boundary no busy", 32'(busy), 32'd0);
    chk("R1 no boundary no access", 32'(log_n), 32'd0);

    // Sweep of every vector
    for (int v = 0; v < 256; v++) begin
      do_entry(8'(v), 32'h8000_0000 | (32'(v) << 4));
      do_return(32'h8000_0000 | (32'(v) << 4));
    end
    chk("R9 request held through stall", 32'(hs_bad), 32'd0);
    chk("R9 stalls exercised", 32'(stalls > 10), 32'd1);

    // R7 bad gates
    for (int m = 1; m <= 2; m++) begin
      bad_mode = m;
      do_reset();
      set_if = 1'b1; @(negedge clk); set_if = 1'b0;
      pulse_irq(8'h33, 32'h0000_0500);
      repeat (60) @(negedge clk);
      chk("R7 fault raised", 32'(fault), 32'd1);
      chk("R7 busy held", 32'(busy), 32'd1);
      chk("R7 no more requests", {31'd0, mem_valid}, 32'd0);
      chk("R7 transfers before halt", 32'(log_n), 32'd5);
      chk("R7 cs kept", 32'(cs_o), 32'h8);
      chk("R7 ip kept", ip_o, 32'h0000_0500);
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule